// File: doc/BRIEF.md
# Delayed Read Prefetch Controller

This block sits between a bus master that issues word reads, with classic cycle, strobe, acknowledge and retry handshakes, and a slower downstream memory path that performs burst reads. A read request that finds the controller idle is never served on the spot. The controller answers it with a retry, records its word address, and issues one burst request downstream. The returned words fill a small local buffer. The master is expected to come back later with the same read.

When the repeated read starts at the recorded address and walks upward one word per beat, each beat whose word is already in the buffer is acknowledged with that word. A beat whose word is still on its way is retried. Any other address ends the transaction and throws the buffered data away. The burst length depends on a flag the master raises when it first asks. With the flag raised, the whole buffer depth is fetched. Without it, a single word is fetched, so no downstream bandwidth goes to data that would be dropped. Words that arrive after a transaction has been abandoned are still accepted from downstream, then discarded.

The downstream side uses valid/ready in both directions. The request (address and length) stays valid and unchanged until ready is seen. Response words move on any cycle where both valid and ready are high. The controller raises response ready only while words of the current burst are still outstanding, so the downstream side must hold a word until it is taken.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: While reset is asserted and right after it, up_ack, up_rty, dn_req_valid and dn_rsp_ready are all low.
- R2: A beat (up_cyc and up_stb high) that finds the controller idle is answered with up_rty in the same cycle. The address is recorded, and from the next cycle dn_req_valid is high with dn_req_addr equal to that address. Request fields hold until dn_req_ready is seen.
- R3: Every beat gets exactly one of up_ack or up_rty in the same cycle. Neither is raised in a cycle without a beat.
- R4: A repeated beat at address base+k, where k counts the words already delivered in this transaction, is acknowledged when word k has arrived. up_dat then carries the downstream word for address base+k.
- R5: A beat at address base+k whose word has not yet arrived, while the burst is still in progress, is retried and leaves the transaction in place.
- R6: A beat at any address other than base+k is retried and invalidates the buffer. Later beats are retried until outstanding words are drained, after which a beat starts a new fetch.
- R7: A beat at base+len, after every fetched word has been delivered, is retried and returns the controller to idle, so the following beat starts a new fetch.
- R8: The burst length on dn_req_len is DEPTH when up_burst is 1 at the first beat, and 1 when it is 0.
- R9: Dropping up_cyc after at least one word has been delivered ends the transaction. Words still outstanding are accepted and dropped, and beats during that drain are retried.
- R10: dn_rsp_ready is high exactly while words of the current burst are outstanding and the transaction is either filling or draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cyc | input | 1 | Master cycle: high for the whole block transfer |
| up_stb | input | 1 | Master strobe: a beat when high together with up_cyc |
| up_adr | input | ADDR_W | Word address of the beat |
| up_burst | input | 1 | At the first beat: 1 asks for a full-depth sequential prefetch |
| up_ack | output | 1 | Beat served, up_dat valid |
| up_rty | output | 1 | Beat refused, master must repeat |
| up_dat | output | DATA_W | Read data for an acknowledged beat |
| dn_req_valid | output | 1 | Burst request valid |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_req_addr | output | ADDR_W | First word address of the burst |
| dn_req_len | output | CNT_W | Number of words in the burst |
| dn_rsp_valid | input | 1 | Downstream word valid |
| dn_rsp_ready | output | 1 | Controller takes the word |
| dn_rsp_data | input | DATA_W | Downstream word, in ascending address order |

## Verification
The bench builds the block with its defaults: DEPTH of 8 and 16-bit word addresses. Full eight-word bursts therefore reach the overrun beat at base+8, and single-word fetches reach the overrun at base+1. Downstream readiness and response gaps follow fixed cycle patterns. As a result, stalled request handshakes, waits for words still in flight, and strays or cycle drops that land in the middle of a fill all arise and are compared against a behavioural model on every clock.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READY = 2'd2,
    ST_DRAIN = 2'd3
  } pfc_state_e;
endpackage

// File: rtl/pfc_word_store.sv
module pfc_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) slot_q[i] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/pfc_fetch_track.sv
module pfc_fetch_track #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [CNT_W-1:0]  launch_len,
  input  logic              req_ready,
  input  logic              rsp_take,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [CNT_W-1:0]  req_len,
  output logic [CNT_W-1:0]  got,
  output logic              complete
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  got_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      got_q  <= '0;
    end else if (launch) begin
      pend_q <= 1'b1;
      addr_q <= launch_addr;
      len_q  <= launch_len;
      got_q  <= '0;
    end else begin
      if (pend_q && req_ready) pend_q <= 1'b0;
      if (rsp_take) got_q <= got_q + 1'b1;
    end
  end

  assign req_valid = pend_q;
  assign req_addr  = addr_q;
  assign req_len   = len_q;
  assign got       = got_q;
  assign complete  = (got_q == len_q);
endmodule

// File: rtl/pfc_beat_judge.sv
module pfc_beat_judge #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              serving,
  input  logic              beat,
  input  logic              cyc,
  input  logic [ADDR_W-1:0] adr,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  rdx,
  input  logic [CNT_W-1:0]  got,
  input  logic [CNT_W-1:0]  len,
  output logic              hit,
  output logic              stray,
  output logic              overrun,
  output logic              finish
);
  logic [ADDR_W-1:0] want_adr;
  logic              adr_ok;
  logic              word_in;

  assign want_adr = base + ADDR_W'(rdx);
  assign adr_ok   = (adr == want_adr);
  assign word_in  = (rdx < got);

  assign hit     = serving && beat && adr_ok && word_in;
  assign overrun = serving && beat && adr_ok && !word_in && (rdx >= len);
  assign stray   = serving && beat && !adr_ok;
  assign finish  = serving && !cyc && (rdx != '0);
endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_cyc,
  input  logic              up_stb,
  input  logic [ADDR_W-1:0] up_adr,
  input  logic              up_burst,
  output logic              up_ack,
  output logic              up_rty,
  output logic [DATA_W-1:0] up_dat,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic [CNT_W-1:0]  dn_req_len,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_data
);
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_LEN  = CNT_W'(1);

  pfc_state_e       state_q, state_d;
  logic [CNT_W-1:0] rdx_q, rdx_d;

  logic             beat, serving, launch, take, last_take;
  logic             hit, stray, overrun, finish;
  logic [CNT_W-1:0] got;
  logic             complete;

  assign beat    = up_cyc && up_stb;
  assign serving = (state_q == ST_FETCH) || (state_q == ST_READY);

  pfc_fetch_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_addr (up_adr),
    .launch_len  (up_burst ? FULL_LEN : ONE_LEN),
    .req_ready   (dn_req_ready),
    .rsp_take    (take),
    .req_valid   (dn_req_valid),
    .req_addr    (dn_req_addr),
    .req_len     (dn_req_len),
    .got         (got),
    .complete    (complete)
  );

  pfc_beat_judge #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_judge (
    .serving (serving),
    .beat    (beat),
    .cyc     (up_cyc),
    .adr     (up_adr),
    .base    (dn_req_addr),
    .rdx     (rdx_q),
    .got     (got),
    .len     (dn_req_len),
    .hit     (hit),
    .stray   (stray),
    .overrun (overrun),
    .finish  (finish)
  );

  pfc_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (take && (state_q == ST_FETCH)),
    .wr_idx  (got[IDX_W-1:0]),
    .wr_data (dn_rsp_data),
    .rd_idx  (rdx_q[IDX_W-1:0]),
    .rd_data (up_dat)
  );

  // Words are taken only while the current burst still owes some.
  assign dn_rsp_ready = ((state_q == ST_FETCH) || (state_q == ST_DRAIN)) && !complete;
  assign take         = dn_rsp_valid && dn_rsp_ready;
  assign last_take    = take && (CNT_W'(got + 1'b1) == dn_req_len);

  assign up_ack = hit;
  assign up_rty = beat && !hit;

  always_comb begin
    state_d = state_q;
    rdx_d   = rdx_q;
    launch  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (beat) begin
          launch  = 1'b1;
          rdx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (hit) rdx_d = rdx_q + 1'b1;
        if (stray || overrun || finish) state_d = ST_DRAIN;
        else if (last_take)             state_d = ST_READY;
      end
      ST_READY: begin
        if (hit) rdx_d = rdx_q + 1'b1;
        if (stray || overrun || finish) state_d = ST_IDLE;
      end
      ST_DRAIN: begin
        if (complete && !dn_req_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdx_q   <= '0;
    end else begin
      state_q <= state_d;
      rdx_q   <= rdx_d;
    end
  end
endmodule

// File: rtl/pfc_props.sv
module pfc_props
  import pfc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_cyc,
  input logic              up_stb,
  input logic              up_ack,
  input logic              up_rty,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic [CNT_W-1:0]  dn_req_len,
  input logic              dn_rsp_ready,
  input pfc_state_e        state
);
  logic beat;
  assign beat = up_cyc && up_stb;

  // R3
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_ack && up_rty));

  // R3
  resp_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack || up_rty) |-> beat);

  // R3
  beat_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (up_ack || up_rty));

  // R2
  idle_beat_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && beat) |-> up_rty ##1 dn_req_valid);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_len)));

  // R4
  ack_when_serving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack |-> (state == ST_FETCH || state == ST_READY));

  // R10
  rsp_ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_ready |-> (state == ST_FETCH || state == ST_DRAIN));
endmodule

bind rd_prefetch_ctrl pfc_props #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_props (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_cyc       (up_cyc),
  .up_stb       (up_stb),
  .up_ack       (up_ack),
  .up_rty       (up_rty),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_addr  (dn_req_addr),
  .dn_req_len   (dn_req_len),
  .dn_rsp_ready (dn_rsp_ready),
  .state        (state_q)
);

// File: tb/tb_rd_prefetch_ctrl.sv
module tb_rd_prefetch_ctrl;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          up_cyc, up_stb, up_burst;
  logic [AW-1:0] up_adr;
  logic          up_ack, up_rty;
  logic [DW-1:0] up_dat;
  logic          dn_req_valid, dn_req_ready;
  logic [AW-1:0] dn_req_addr;
  logic [CW-1:0] dn_req_len;
  logic          dn_rsp_valid, dn_rsp_ready;
  logic [DW-1:0] dn_rsp_data;

  rd_prefetch_ctrl #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .up_cyc(up_cyc), .up_stb(up_stb), .up_adr(up_adr), .up_burst(up_burst),
    .up_ack(up_ack), .up_rty(up_rty), .up_dat(up_dat),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_req_len(dn_req_len),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_data(dn_rsp_data)
  );

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;

  // Behavioural model: 0 idle, 1 filling, 2 full, 3 draining
  int            mst = 0, mcnt = 0, mlen = 0, midx = 0;
  bit            mreqv = 1'b0;
  logic [AW-1:0] mbase = '0;
  logic [DW-1:0] rq[$];

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return (DW'(a) * 32'h0001_0003) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit c, input bit s, input logic [AW-1:0] a, input bit q,
                      output bit acked);
    string         why;
    bit            eack, erty, erdr, take, oreqv;
    int            ost, ocnt;
    logic [AW-1:0] want;
    @(negedge clk);
    up_cyc = c; up_stb = s; up_adr = a; up_burst = q;
    dn_req_ready = (ncyc % 3) != 0;
    dn_rsp_valid = (rq.size() > 0) && ((ncyc % 4) != 1);
    dn_rsp_data  = (rq.size() > 0) ? rq[0] : '0;
    ncyc++;
    #4;
    eack = 1'b0; erty = 1'b0; why = "R3";
    ost = mst; ocnt = mcnt; oreqv = mreqv;
    erdr = (ost == 1 || ost == 3) && (mcnt < mlen);
    take = erdr && dn_rsp_valid;
    chk("R2", "req_valid", dn_req_valid, mreqv);
    if (mreqv) begin
      chk("R2", "req_addr", dn_req_addr, mbase);
      chk(mlen == 1 ? "R8" : "R2", "req_len", dn_req_len, mlen);
    end
    chk("R10", "rsp_ready", dn_rsp_ready, erdr);
    if (mreqv && dn_req_ready) begin
      for (int i = 0; i < mlen; i++) rq.push_back(memf(mbase + AW'(i)));
      mreqv = 1'b0;
    end
    want = mbase + AW'(midx);
    case (ost)
      0: if (c && s) begin
        erty = 1'b1; why = "R2";
        mst = 1; mbase = a; mlen = q ? DEPTH : 1; mcnt = 0; midx = 0; mreqv = 1'b1;
      end
      1, 2: begin
        if (c && s) begin
          if (a == want) begin
            if (midx < mcnt) begin eack = 1'b1; why = "R4"; midx++; end
            else if (midx >= mlen) begin erty = 1'b1; why = "R7"; mst = (ost == 1) ? 3 : 0; end
            else begin erty = 1'b1; why = "R5"; end
          end else begin
            erty = 1'b1; why = "R6"; mst = (ost == 1) ? 3 : 0;
          end
        end else if (!c && midx > 0) begin
          why = "R9"; mst = (ost == 1) ? 3 : 0;
        end
      end
      default: if (c && s) begin erty = 1'b1; why = "R9"; end
    endcase
    if (take) begin
      void'(rq.pop_front());
      mcnt++;
    end
    if (ost == 1 && mst == 1 && take && mcnt == mlen) mst = 2;
    if (ost == 3 && ocnt == mlen && !oreqv) mst = 0;
    chk(why, "ack", up_ack, eack);
    chk(why, "rty", up_rty, erty);
    if (eack) chk("R4", "data", up_dat, memf(a));
    acked = eack;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    bit ak;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, ak);
  endtask

  task automatic launch(input logic [AW-1:0] a, input bit q);
    bit ak;
    step(1'b1, 1'b1, a, q, ak);
    step(1'b0, 1'b0, '0, 1'b0, ak);
  endtask

  task automatic read_words(input logic [AW-1:0] a, input int n, input bit q);
    bit ak;
    int k = 0;
    for (int g = 0; g < 300 && k < n; g++) begin
      step(1'b1, 1'b1, a + AW'(k), q, ak);
      if (ak) k++;
    end
    chk("R4", "words_read", k, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ak;
    rst_n = 1'b0;
    up_cyc = 1'b0; up_stb = 1'b0; up_adr = '0; up_burst = 1'b0;
    dn_req_ready = 1'b0; dn_rsp_valid = 1'b0; dn_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ack", up_ack, 0);
    chk("R1", "rty", up_rty, 0);
    chk("R1", "req_valid", dn_req_valid, 0);
    chk("R1", "rsp_ready", dn_rsp_ready, 0);
    rst_n = 1'b1;
    idle(2);

    // Full sequential burst, master repeats at once and waits on words (R5), overrun (R7)
    launch(16'h0100, 1'b1);
    read_words(16'h0100, DEPTH, 1'b1);
    step(1'b1, 1'b1, 16'h0108, 1'b1, ak);
    idle(2);

    // Single-word fetch (R8), served, then overrun at base+1
    launch(16'h0200, 1'b0);
    idle(6);
    read_words(16'h0200, 1, 1'b0);
    step(1'b1, 1'b1, 16'h0201, 1'b0, ak);
    idle(2);

    // Start mismatch during fill (R6), beats during drain retried (R9)
    launch(16'h0300, 1'b1);
    step(1'b1, 1'b1, 16'h0304, 1'b1, ak);
    step(1'b1, 1'b1, 16'h0300, 1'b1, ak);
    step(1'b1, 1'b1, 16'h0300, 1'b1, ak);
    idle(24);
    launch(16'h0304, 1'b1);
    read_words(16'h0304, DEPTH, 1'b1);
    step(1'b1, 1'b1, 16'h030C, 1'b1, ak);
    idle(2);

    // Buffer full, partial read, then non-sequential jump (R6)
    launch(16'h0400, 1'b1);
    idle(24);
    read_words(16'h0400, 3, 1'b1);
    step(1'b1, 1'b1, 16'h0410, 1'b1, ak);
    idle(2);

    // Cycle dropped mid-fill after two words (R9)
    launch(16'h0500, 1'b1);
    read_words(16'h0500, 2, 1'b1);
    idle(1);
    step(1'b1, 1'b1, 16'h0502, 1'b1, ak);
    idle(24);

    // Wrap of the address space within a burst
    launch(16'hFFFC, 1'b1);
    read_words(16'hFFFC, DEPTH, 1'b1);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule